// File: doc/BRIEF.md
# CSR Access Unit with Floating-Point Aliases

This unit executes the six read-modify-write operations on control and status registers: overwrite, bit-set and bit-clear, each in a register-operand form and a 5-bit immediate form. A request carries a 12-bit register address, a 3-bit operation code, the operand, a flag saying the source register index is zero, and a flag saying the destination register index is zero. One cycle after a request is accepted, the unit returns the value the register held before the operation, plus a register-file write enable.

The storage is small: one 8-bit floating-point control register, one address-translation register, and a parameterised bank of full-width scratch registers. The floating-point exception flags and rounding mode have no storage of their own. Their addresses are bit-field views into the combined control register. A write that reaches the address-translation register raises a one-cycle notify pulse toward the memory-management unit, carrying the value written.

Control is a two-state machine. `ST_IDLE` accepts a request (transition *accept*, when `req_valid` is high). It reads the old value, computes the new value and latches both. `ST_COMMIT` presents the response and performs the latched write. It always returns to `ST_IDLE` (transition *retire*). `req_ready` is high only in `ST_IDLE`.

Top module: `csr_rmw_unit`

## Requirements
- R1: Operation code 001 writes the operand as is. Operation code 101 writes the operand's bits [4:0] zero-extended to the full width.
- R2: Codes 010 and 110 write old OR source, and codes 011 and 111 write old AND NOT source. The register forms use the full operand as the source; the immediate forms use operand bits [4:0] zero-extended.
- R3: A set or clear performs no write when its source is absent: `req_src_zero` high for the register forms (010, 011), or operand bits [4:0] all zero for the immediate forms (110, 111). The old value is still returned.
- R4: Address 0x001 reads as bits [4:0] of the control register at 0x003, zero-extended. A write to it replaces only those bits, using operand bits [4:0].
- R5: Address 0x002 reads as bits [7:5] of the control register, zero-extended. A write to it replaces only those bits, using operand bits [2:0].
- R6: A write to 0x003 keeps only bits [7:0] of the value, and a read of 0x003 returns them zero-extended.
- R7: A write to address 0x180 stores the full value and sets `mmu_notify` for exactly the response cycle, with `mmu_value` equal to the stored value. No pulse occurs for other addresses or for a skipped write.
- R8: `resp_rd_we` is high in the response cycle exactly when `req_dst_zero` was low at acceptance.
- R9: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `resp_valid` is high for the single following cycle, and `req_ready` is low during it. `resp_old` is the register's state before the write, and the write is visible to the next request.
- R10: Addresses with no storage read as zero, and writes to them change nothing.
- R11: `NUM_SCRATCH` scratch registers sit at consecutive addresses from `SCRATCH_BASE` (default 0x340, four registers), each holding a full-width value.
- R12: After reset, `req_ready` is high, `resp_valid` and `mmu_notify` are low, and every register reads zero.
- R13: Operation codes 000 and 100 write nothing, but still return the old value and the usual write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 12 | Register address |
| req_op | input | 3 | Operation code |
| req_operand | input | XLEN | Source register value, or immediate in bits [4:0] |
| req_src_zero | input | 1 | Source register index is zero |
| req_dst_zero | input | 1 | Destination register index is zero |
| resp_valid | output | 1 | Response cycle |
| resp_old | output | XLEN | Register value before the operation |
| resp_rd_we | output | 1 | Register-file write enable |
| mmu_notify | output | 1 | Address-translation register was written |
| mmu_value | output | XLEN | Value written to the address-translation register |

## Verification
The response to a request accepted on a given edge (`resp_valid`, `resp_old`, `resp_rd_we`, `mmu_notify`, `mmu_value`) is due during the one cycle that follows that edge. The bench samples it at the falling edge inside that cycle. The write lands on the next rising edge, when `req_ready` also returns high. Its effect is therefore checked only through the `resp_old` of a later request, and the idle cycle between requests is checked for a quiet response. The expected values come from a behavioural model of the registers that is updated only after each response has been compared.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
    localparam int ADDR_W = 12;
    localparam int FLAG_W = 5;
    localparam int RND_W  = 3;
    localparam int FCTL_W = FLAG_W + RND_W;
    localparam int IMM_W  = 5;

    localparam logic [ADDR_W-1:0] ADR_FFLAG = 12'h001;
    localparam logic [ADDR_W-1:0] ADR_FRND  = 12'h002;
    localparam logic [ADDR_W-1:0] ADR_FCTL  = 12'h003;
    localparam logic [ADDR_W-1:0] ADR_XLAT  = 12'h180;

    localparam logic [2:0] OP_RW  = 3'b001;
    localparam logic [2:0] OP_RS  = 3'b010;
    localparam logic [2:0] OP_RC  = 3'b011;
    localparam logic [2:0] OP_RWI = 3'b101;
    localparam logic [2:0] OP_RSI = 3'b110;
    localparam logic [2:0] OP_RCI = 3'b111;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } csr_state_e;
endpackage

// File: rtl/csr_op_alu.sv
module csr_op_alu
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    input  logic            src_zero,
    output logic            wr_en,
    output logic [XLEN-1:0] wr_data
);
    logic [XLEN-1:0] src;
    logic            no_src;

    always_comb begin
        // immediate forms take a zero-extended 5-bit field
        src    = op[2] ? {{(XLEN-IMM_W){1'b0}}, operand[IMM_W-1:0]} : operand;
        no_src = op[2] ? (operand[IMM_W-1:0] == '0) : src_zero;
        wr_en   = 1'b0;
        wr_data = old_val;
        case (op)
            OP_RW, OP_RWI: begin
                wr_en   = 1'b1;
                wr_data = src;
            end
            OP_RS, OP_RSI: begin
                wr_en   = !no_src;
                wr_data = old_val | src;
            end
            OP_RC, OP_RCI: begin
                wr_en   = !no_src;
                wr_data = old_val & ~src;
            end
            default: begin
                wr_en   = 1'b0;
                wr_data = old_val;
            end
        endcase
    end
endmodule

// File: rtl/csr_store.sv
module csr_store
    import csr_rmw_pkg::*;
#(
    parameter int                XLEN         = 32,
    parameter int                NUM_SCRATCH  = 4,
    parameter logic [ADDR_W-1:0] SCRATCH_BASE = 12'h340
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [XLEN-1:0]   rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [XLEN-1:0]   wr_data
);
    logic [FCTL_W-1:0]    fctl_q;
    logic [XLEN-1:0]      xlat_q;
    logic [XLEN-1:0]      slot_q [NUM_SCRATCH];
    logic [NUM_SCRATCH-1:0] slot_hit_rd;
    logic [NUM_SCRATCH-1:0] slot_hit_wr;

    // combined floating-point control register with its two field views
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fctl_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_FFLAG: fctl_q[FLAG_W-1:0]      <= wr_data[FLAG_W-1:0];
                ADR_FRND:  fctl_q[FCTL_W-1:FLAG_W] <= wr_data[RND_W-1:0];
                ADR_FCTL:  fctl_q                  <= wr_data[FCTL_W-1:0];
                default:   fctl_q                  <= fctl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xlat_q <= '0;
        end else if (wr_en && wr_addr == ADR_XLAT) begin
            xlat_q <= wr_data;
        end
    end

    for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADR = SCRATCH_BASE + ADDR_W'(i);
        assign slot_hit_rd[i] = (rd_addr == SLOT_ADR);
        assign slot_hit_wr[i] = (wr_addr == SLOT_ADR);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (wr_en && slot_hit_wr[i]) begin
                slot_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_FFLAG: rd_data[FLAG_W-1:0] = fctl_q[FLAG_W-1:0];
            ADR_FRND:  rd_data[RND_W-1:0]  = fctl_q[FCTL_W-1:FLAG_W];
            ADR_FCTL:  rd_data[FCTL_W-1:0] = fctl_q;
            ADR_XLAT:  rd_data             = xlat_q;
            default: begin
                for (int i = 0; i < NUM_SCRATCH; i++) begin
                    if (slot_hit_rd[i]) begin
                        rd_data = rd_data | slot_q[i];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int                XLEN         = 32,
    parameter int                NUM_SCRATCH  = 4,
    parameter logic [ADDR_W-1:0] SCRATCH_BASE = 12'h340
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_op,
    input  logic [XLEN-1:0]   req_operand,
    input  logic              req_src_zero,
    input  logic              req_dst_zero,
    output logic              resp_valid,
    output logic [XLEN-1:0]   resp_old,
    output logic              resp_rd_we,
    output logic              mmu_notify,
    output logic [XLEN-1:0]   mmu_value
);
    csr_state_e        state_q, state_d;
    logic              accept;
    logic [XLEN-1:0]   cur_val;
    logic              calc_we;
    logic [XLEN-1:0]   calc_data;
    logic [ADDR_W-1:0] addr_q;
    logic [XLEN-1:0]   old_q;
    logic [XLEN-1:0]   new_q;
    logic              we_q;
    logic              dstz_q;
    logic              commit_we;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign commit_we = (state_q == ST_COMMIT) && we_q;

    csr_store #(
        .XLEN        (XLEN),
        .NUM_SCRATCH (NUM_SCRATCH),
        .SCRATCH_BASE(SCRATCH_BASE)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_addr(req_addr),
        .rd_data(cur_val),
        .wr_en  (commit_we),
        .wr_addr(addr_q),
        .wr_data(new_q)
    );

    csr_op_alu #(
        .XLEN(XLEN)
    ) u_alu (
        .op      (req_op),
        .old_val (cur_val),
        .operand (req_operand),
        .src_zero(req_src_zero),
        .wr_en   (calc_we),
        .wr_data (calc_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept (IDLE->COMMIT), retire (COMMIT->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    // request capture on accept: old value is latched before any write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            old_q  <= '0;
            new_q  <= '0;
            we_q   <= 1'b0;
            dstz_q <= 1'b1;
        end else if (accept) begin
            addr_q <= req_addr;
            old_q  <= cur_val;
            new_q  <= calc_data;
            we_q   <= calc_we;
            dstz_q <= req_dst_zero;
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_old   = '0;
        resp_rd_we = 1'b0;
        mmu_notify = 1'b0;
        mmu_value  = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_COMMIT: begin
                resp_valid = 1'b1;
                resp_old   = old_q;
                resp_rd_we = !dstz_q;
                mmu_notify = we_q && (addr_q == ADR_XLAT);
                mmu_value  = mmu_notify ? new_q : '0;
            end
        endcase
    end
endmodule

// File: rtl/csr_rmw_unit_chk.sv
module csr_rmw_unit_chk
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_op,
    input logic              req_src_zero,
    input logic              req_dst_zero,
    input logic              resp_valid,
    input logic [XLEN-1:0]   resp_old,
    input logic              resp_rd_we,
    input logic              mmu_notify
);
    assert_resp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_accept_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && req_ready));

    assert_notify_in_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_notify |-> resp_valid);

    assert_notify_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_notify |-> $past(req_addr) == ADR_XLAT);

    assert_rdwe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_rd_we == !$past(req_dst_zero)));

    assert_skip_notify_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(req_addr == ADR_XLAT && req_src_zero &&
                             (req_op == OP_RS || req_op == OP_RC))) |-> !mmu_notify);

    assert_flag_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(req_addr == ADR_FFLAG)) |-> resp_old[XLEN-1:FLAG_W] == '0);
endmodule

bind csr_rmw_unit csr_rmw_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_op      (req_op),
    .req_src_zero(req_src_zero),
    .req_dst_zero(req_dst_zero),
    .resp_valid  (resp_valid),
    .resp_old    (resp_old),
    .resp_rd_we  (resp_rd_we),
    .mmu_notify  (mmu_notify)
);

// File: tb/csr_rmw_unit_bench.sv
module csr_rmw_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_operand = '0;
    logic        req_src_zero = 1'b0;
    logic        req_dst_zero = 1'b0;
    logic        resp_valid;
    logic [31:0] resp_old;
    logic        resp_rd_we;
    logic        mmu_notify;
    logic [31:0] mmu_value;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural register model
    logic [7:0]  m_fctl = '0;
    logic [31:0] m_xlat = '0;
    logic [31:0] m_slot [4] = '{default: '0};

    always #10 clk = ~clk;

    csr_rmw_unit u_csr_rmw_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_op(req_op), .req_operand(req_operand),
        .req_src_zero(req_src_zero), .req_dst_zero(req_dst_zero),
        .resp_valid(resp_valid), .resp_old(resp_old), .resp_rd_we(resp_rd_we),
        .mmu_notify(mmu_notify), .mmu_value(mmu_value)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [11:0] a);
        if (a == 12'h001) return {27'd0, m_fctl[4:0]};
        if (a == 12'h002) return {29'd0, m_fctl[7:5]};
        if (a == 12'h003) return {24'd0, m_fctl};
        if (a == 12'h180) return m_xlat;
        if (a >= 12'h340 && a <= 12'h343) return m_slot[a - 12'h340];
        return 32'd0;
    endfunction

    task automatic m_write(logic [11:0] a, logic [31:0] v);
        if (a == 12'h001) m_fctl[4:0] = v[4:0];
        else if (a == 12'h002) m_fctl[7:5] = v[2:0];
        else if (a == 12'h003) m_fctl = v[7:0];
        else if (a == 12'h180) m_xlat = v;
        else if (a >= 12'h340 && a <= 12'h343) m_slot[a - 12'h340] = v;
    endtask

    // one transaction; called at a falling edge with the unit idle
    task automatic xact(string req, logic [11:0] a, logic [2:0] op, logic [31:0] opnd,
                        bit sz, bit dz);
        logic [31:0] old_e, src, nv;
        bit          wr;
        old_e = m_read(a);
        src   = op[2] ? (opnd & 32'h1F) : opnd;
        wr    = 0;
        nv    = old_e;
        if (op == 3'b001 || op == 3'b101) begin wr = 1; nv = src; end
        else if (op == 3'b010 || op == 3'b110) begin wr = (src != 0) && !(op == 3'b010 && sz); nv = old_e | src; end
        else if (op == 3'b011 || op == 3'b111) begin wr = (src != 0) && !(op == 3'b011 && sz); nv = old_e & ~src; end
        if (op == 3'b010 || op == 3'b011) wr = !sz;
        req_valid = 1; req_addr = a; req_op = op; req_operand = opnd;
        req_src_zero = sz; req_dst_zero = dz;
        @(negedge clk);
        req_valid = 0;
        check({"R9 resp_valid ", req}, 32'(resp_valid), 32'd1);
        check({"R9 ready low ", req}, 32'(req_ready), 32'd0);
        check({req, " old value"}, resp_old, old_e);
        check({"R8 rd_we ", req}, 32'(resp_rd_we), 32'(!dz));
        check({"R7 notify ", req}, 32'(mmu_notify), 32'(wr && a == 12'h180));
        if (wr && a == 12'h180) check({"R7 value ", req}, mmu_value, nv);
        if (wr) m_write(a, nv);
        @(negedge clk);
        check({"R9 idle resp ", req}, 32'(resp_valid), 32'd0);
        check({"R9 idle ready ", req}, 32'(req_ready), 32'd1);
        check({"R7 idle notify ", req}, 32'(mmu_notify), 32'd0);
    endtask

    // read-only probe: set with zero source
    task automatic peek(string req, logic [11:0] a);
        xact(req, a, 3'b010, 32'hFFFF_FFFF, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 ready", 32'(req_ready), 32'd1);
        check("R12 resp_valid", 32'(resp_valid), 32'd0);
        check("R12 notify", 32'(mmu_notify), 32'd0);
        rst_n = 1;
        @(negedge clk);
        peek("R12 fctl", 12'h003);
        peek("R12 flags", 12'h001);
        peek("R12 rnd", 12'h002);
        peek("R12 xlat", 12'h180);
        peek("R12 slot", 12'h340);
        // R1 write forms
        xact("R1 rw", 12'h340, 3'b001, 32'hDEAD_BEEF, 0, 0);
        xact("R1 rwi", 12'h341, 3'b101, 32'hFFFF_FFF3, 0, 0);
        peek("R1 readback", 12'h340);
        peek("R1 readback imm", 12'h341);
        // R2 set/clear
        xact("R2 rs", 12'h340, 3'b010, 32'h0000_00F0, 0, 0);
        xact("R2 rc", 12'h340, 3'b011, 32'hDEAD_0000, 0, 0);
        xact("R2 rsi", 12'h341, 3'b110, 32'h0000_000C, 0, 0);
        xact("R2 rci", 12'h341, 3'b111, 32'hFFFF_FFE3, 0, 0);
        peek("R2 readback", 12'h340);
        // R3 skipped writes
        xact("R3 rs zero src", 12'h340, 3'b010, 32'hFFFF_0000, 1, 0);
        xact("R3 rc zero src", 12'h340, 3'b011, 32'hFFFF_FFFF, 1, 0);
        xact("R3 rsi zero imm", 12'h341, 3'b110, 32'hFFFF_FFE0, 0, 0);
        xact("R3 rci zero imm", 12'h341, 3'b111, 32'h0000_FFE0, 0, 0);
        peek("R3 readback", 12'h340);
        peek("R3 readback imm", 12'h341);
        // R6 combined register
        xact("R6 fctl write", 12'h003, 3'b001, 32'h0001_2345, 0, 0);
        peek("R6 fctl read", 12'h003);
        // R4 flag view
        peek("R4 flag read", 12'h001);
        xact("R4 flag write", 12'h001, 3'b001, 32'hFFFF_FFFF, 0, 0);
        peek("R4 fctl after flags", 12'h003);
        // R5 rounding view
        peek("R5 rnd read", 12'h002);
        xact("R5 rnd write", 12'h002, 3'b001, 32'h0000_000D, 0, 0);
        peek("R5 fctl after rnd", 12'h003);
        xact("R5 rnd setimm", 12'h002, 3'b110, 32'h0000_0002, 0, 0);
        xact("R4 flag clear", 12'h001, 3'b011, 32'h0000_001F, 0, 0);
        peek("R5 fctl final", 12'h003);
        // R7 translation register
        xact("R7 xlat write", 12'h180, 3'b001, 32'h8000_1234, 0, 0);
        xact("R7 xlat skipped", 12'h180, 3'b010, 32'h0000_00FF, 1, 0);
        xact("R7 xlat setimm", 12'h180, 3'b110, 32'h0000_0001, 0, 0);
        peek("R7 xlat readback", 12'h180);
        // R8 destination zero
        xact("R8 dst zero", 12'h340, 3'b001, 32'h1357_9BDF, 0, 1);
        peek("R8 readback", 12'h340);
        // R10 unimplemented
        xact("R10 hole write", 12'h7C0, 3'b001, 32'hFFFF_FFFF, 0, 0);
        peek("R10 hole read", 12'h7C0);
        xact("R10 past slots", 12'h344, 3'b001, 32'hA5A5_A5A5, 0, 0);
        peek("R10 past slots read", 12'h344);
        // R11 last scratch slot
        xact("R11 top slot", 12'h343, 3'b001, 32'hFEDC_BA98, 0, 0);
        peek("R11 top slot read", 12'h343);
        peek("R11 neighbour", 12'h342);
        // R13 reserved codes
        xact("R13 op000", 12'h340, 3'b000, 32'h0000_0000, 0, 0);
        xact("R13 op100", 12'h340, 3'b100, 32'hFFFF_FFFF, 0, 1);
        peek("R13 readback", 12'h340);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule